// File: doc/BRIEF.md
# Repeating-Message Serial Transmitter

This block streams a fixed text message, one character after another and without end, on a single asynchronous serial output line. Each character goes out as a standard 8N1 frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. No parity bit is sent. The bit time is set by a clock-enable counter that runs from the system clock, so the design has a single clock domain and no derived clock. The defaults are a 50 MHz system clock and 9600 baud, which gives 5208 system clocks per bit.

The block holds its own character store. A pointer selects the character for the next frame, steps forward once after every stop bit, and returns to zero after the last character. The default message is "Hello World!". While the enable input is high, frames follow each other with no gap. Dropping enable never cuts a frame short: the frame in flight is completed and the line then rests high. A synchronous reset returns the transmitter to idle and the pointer to the first character.

Top module: `msg_uart_tx`

## Requirements
- R1: The txd line is high while the block is idle, both when enable is low and while reset is applied.
- R2: Each frame is a start bit at 0, then the 8 data bits with bit 0 first, then a stop bit at 1, with no parity bit.
- R3: Every bit lasts exactly CLK_HZ/BAUD system clocks (5208 with the default parameters). The ticks that mark bit boundaries are never closer together than two clocks.
- R4: The controller steps through idle, start, data bit 0 to data bit 7 and stop in that order. Outside idle it changes state only on a bit tick.
- R5: Characters go out in message order, starting at index 0. The default message is "Hello World!" (0x48 0x65 0x6C 0x6C 0x6F 0x20 0x57 0x6F 0x72 0x6C 0x64 0x21).
- R6: After the frame for the last character (index MSG_LEN-1), the next character sent is index 0. The pointer never holds a value of MSG_LEN or above.
- R7: When enable is high at the end of a stop bit, the next start bit begins on the following clock, so consecutive start edges are 10*CLK_HZ/BAUD clocks apart.
- R8: If enable is deasserted during a frame, that frame finishes in full with its stop bit and the block then stays idle with txd high. When enable returns, the next frame carries the character after the completed one.
- R9: Synchronous reset, including a reset in the middle of a frame, puts the block in idle with txd high on the next clock. The first frame after reset carries character index 0.
- R10: From idle, a clock edge that finds enable high starts the start bit, so txd goes low right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Transmit enable. While high, frames are sent back to back. |
| txd | output | 1 | Serial data line, high when idle |

## Verification
On every cycle the assertions check the following: the controller holds its state between bit ticks; the tick counter stays within its range and never produces two ticks in a row; the state after a stop bit follows enable; idle moves to start as soon as enable is seen; and the pointer stays in range and wraps to zero. Only the bench scenarios can show the serial content and timing on the line. These include the order of the decoded characters, the LSB-first bit order, the exact distance between consecutive start edges, the completion of a frame after enable drops, and the return to the first character after a reset in mid-frame.

// File: rtl/msg_tx_pkg.sv
package msg_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_START = 4'd1,
    ST_D0    = 4'd2,
    ST_D1    = 4'd3,
    ST_D2    = 4'd4,
    ST_D3    = 4'd5,
    ST_D4    = 4'd6,
    ST_D5    = 4'd7,
    ST_D6    = 4'd8,
    ST_D7    = 4'd9,
    ST_STOP  = 4'd10
  } tx_state_t;

  // System clocks spent in one serial bit.
  function automatic int unsigned clocks_per_bit(int unsigned clk_hz, int unsigned baud);
    return clk_hz / baud;
  endfunction

  // Width of a counter that must hold the values 0 .. n-1.
  function automatic int unsigned index_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // True for the eight data-bit states.
  function automatic logic is_data_state(tx_state_t s);
    return (s >= ST_D0) && (s <= ST_D7);
  endfunction

endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV = 5208
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  import msg_tx_pkg::*;

  localparam int unsigned CW = index_bits(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/char_store.sv
module char_store #(
  parameter int unsigned MSG_LEN = 12,
  parameter logic [8*MSG_LEN-1:0] MSG = "Hello World!"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  output logic [7:0] char_out
);
  import msg_tx_pkg::*;

  localparam int unsigned PW = index_bits(MSG_LEN);
  localparam logic [PW-1:0] LAST_IDX = PW'(MSG_LEN - 1);

  logic [PW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
    end
  end

  // The first character of a string literal sits in the top byte.
  assign char_out = MSG[8*(MSG_LEN - 1 - int'(ptr)) +: 8];

  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST_IDX);

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (advance && ptr == LAST_IDX) |=> ptr == '0);

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import msg_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic [7:0] char_in,
  output tx_state_t  state,
  output logic       frame_done,
  output logic       txd
);

  tx_state_t  nxt;
  logic [7:0] shreg;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (en)   nxt = ST_START;
      ST_START: if (tick) nxt = ST_D0;
      ST_D7:    if (tick) nxt = ST_STOP;
      ST_STOP:  if (tick) nxt = en ? ST_START : ST_IDLE;
      default:  if (tick) nxt = tx_state_t'(state + 4'd1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      shreg <= '0;
    end else begin
      state <= nxt;
      if (state == ST_START && tick) begin
        shreg <= char_in;
      end else if (is_data_state(state) && tick) begin
        shreg <= {1'b0, shreg[7:1]};
      end
    end
  end

  assign frame_done = (state == ST_STOP) && tick;

  always_comb begin
    if (state == ST_START)          txd = 1'b0;
    else if (is_data_state(state))  txd = shreg[0];
    else                            txd = 1'b1;
  end

  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !tick) |=> $stable(state));

  assert_idle_launch_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && en) |=> state == ST_START);

  assert_chain_next_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && en) |=> state == ST_START);

  assert_finish_then_rest_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !en) |=> state == ST_IDLE);

  assert_stop_from_d7_R4: assert property (@(posedge clk) disable iff (rst)
    $changed(state) && state == ST_STOP |-> $past(state) == ST_D7);

endmodule

// File: rtl/msg_uart_tx.sv
module msg_uart_tx #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned BAUD    = 9600,
  parameter int unsigned MSG_LEN = 12,
  parameter logic [8*MSG_LEN-1:0] MSG = "Hello World!"
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic txd
);
  import msg_tx_pkg::*;

  localparam int unsigned DIV = clocks_per_bit(CLK_HZ, BAUD);

  tx_state_t  state;
  logic       baud_tick;
  logic       frame_done;
  logic       running;
  logic [7:0] cur_char;

  assign running = (state != ST_IDLE);

  baud_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (running),
    .tick (baud_tick)
  );

  char_store #(.MSG_LEN(MSG_LEN), .MSG(MSG)) u_store (
    .clk      (clk),
    .rst      (rst),
    .advance  (frame_done),
    .char_out (cur_char)
  );

  frame_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .tick       (baud_tick),
    .char_in    (cur_char),
    .state      (state),
    .frame_done (frame_done),
    .txd        (txd)
  );

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!en && !running) |=> txd);

endmodule

// File: tb/msg_uart_tx_test.sv
module msg_uart_tx_test;

  localparam int CLK_PERIOD = 20;
  localparam int T_CLK_HZ   = 76800;
  localparam int T_BAUD     = 9600;
  localparam int BIT_CLKS   = T_CLK_HZ / T_BAUD;
  localparam int FRAME_CLKS = 10 * BIT_CLKS;
  localparam int N_VEC      = 13;
  // Message order followed by the wrap back to index 0 (R5, R6).
  localparam logic [7:0] EXP_CHARS [N_VEC] = '{
    8'h48, 8'h65, 8'h6C, 8'h6C, 8'h6F, 8'h20, 8'h57,
    8'h6F, 8'h72, 8'h6C, 8'h64, 8'h21, 8'h48};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic txd;
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  logic finished = 1'b0;

  msg_uart_tx #(.CLK_HZ(T_CLK_HZ), .BAUD(T_BAUD)) uut (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .txd (txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Waits for a start edge, then samples each bit at its middle.
  task automatic get_frame(output logic [7:0] b, output logic start_ok,
                           output logic stop_ok, output int t0, output logic found);
    int w = 0;
    while (txd !== 1'b0 && w < 4*FRAME_CLKS) begin
      @(negedge clk);
      w++;
    end
    found = (txd === 1'b0);
    t0 = cyc;
    repeat (BIT_CLKS/2) @(negedge clk);
    start_ok = (txd === 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CLKS) @(negedge clk);
      b[i] = txd;
    end
    repeat (BIT_CLKS) @(negedge clk);
    stop_ok = (txd === 1'b1);
  endtask

  initial begin
    logic [7:0] b;
    logic st, sp, fnd;
    int t0, tprev;
    logic all_high;

    // Reset state (R9, R1)
    repeat (4) @(negedge clk);
    check(txd === 1'b1, "R9 reset line high", int'(txd), 1);
    rst = 1'b0;
    all_high = 1'b1;
    repeat (50) begin
      @(negedge clk);
      if (txd !== 1'b1) all_high = 1'b0;
    end
    check(all_high, "R1 idle while disabled", int'(all_high), 1);

    // Launch from idle (R10)
    en = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R10 start right after enable", int'(txd), 0);

    // Vector walk: message order, framing, spacing
    tprev = 0;
    for (int v = 0; v < N_VEC; v++) begin
      get_frame(b, st, sp, t0, fnd);
      check(fnd, "R7 frame present", int'(fnd), 1);
      check(b == EXP_CHARS[v], (v == N_VEC-1) ? "R6 wrap char" : "R5 char order",
            int'(b), int'(EXP_CHARS[v]));
      check(st && sp, "R2 start/stop bits", int'({st, sp}), 3);
      if (v > 0) check(t0 - tprev == FRAME_CLKS, "R3 R7 start spacing",
                       t0 - tprev, FRAME_CLKS);
      tprev = t0;
    end

    // Disable mid-frame: the current frame completes (R8)
    get_frame(b, st, sp, t0, fnd);
    check(b == 8'h65 && sp, "R8 pre-check frame", int'(b), 8'h65);
    get_frame(b, st, sp, t0, fnd);
    check(b == 8'h6C, "R4 next frame", int'(b), 8'h6C);
    // Wait for the start of the following frame, then drop enable.
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (3*BIT_CLKS) @(negedge clk);
    en = 1'b0;
    repeat (BIT_CLKS/2 - 3*BIT_CLKS + 3*BIT_CLKS) @(negedge clk);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      if (i >= 3) begin
        repeat (BIT_CLKS) @(negedge clk);
      end else begin
        repeat ((i == 0) ? 0 : 0) @(negedge clk);
      end
      if (i >= 3) b[i] = txd;
    end
    repeat (BIT_CLKS) @(negedge clk);
    check(txd === 1'b1, "R8 stop bit after disable", int'(txd), 1);
    check(b[7:3] == 5'b01101, "R8 frame finished", int'(b[7:3]), 5'b01101);
    all_high = 1'b1;
    repeat (3*FRAME_CLKS) begin
      @(negedge clk);
      if (txd !== 1'b1) all_high = 1'b0;
    end
    check(all_high, "R8 rests after frame", int'(all_high), 1);

    // Re-enable: pointer advanced past completed frame (R8)
    en = 1'b1;
    get_frame(b, st, sp, t0, fnd);
    check(b == 8'h6F, "R8 resume char", int'(b), 8'h6F);

    // Reset in mid-frame (R9)
    while (txd !== 1'b0) @(negedge clk);
    repeat (2*BIT_CLKS) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(txd === 1'b1, "R9 reset mid-frame", int'(txd), 1);
    @(negedge clk);
    rst = 1'b0;
    get_frame(b, st, sp, t0, fnd);
    check(b == 8'h48, "R9 first char after reset", int'(b), 8'h48);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule